// File: doc/BRIEF.md
# Floating-Point Exception Flag Collector

This block sits next to a floating-point unit and turns the per-operation status bits that the unit reports into sticky flags held in a floating-point control/status register. Each time the arithmetic side presents a status vector with its valid strobe, the collector folds the individual causes into eight accumulated flags. It then issues a one-cycle exception request if the register's enable bit is set and any flag is set afterwards. Flags left over from earlier operations count towards the request.

The invalid-operation class is reported by nine separate sub-causes. Every one of them sets a shared invalid flag. Two of them also set their own NaN flags, and only the two infinity-arithmetic sub-causes set the infinity flag. Software reads the register and replaces it through a simple write port. Such a write is the only way to clear flags or to change the enable bit. The arithmetic itself and the vectoring to a handler belong to other blocks.

Top module: `fpx_collector`

## Requirements
- R1: After reset the register output `csr_q` is all zeros and `exc_req` is low.
- R2: A write (`csr_we`=1) replaces the register on the next clock edge with `csr_wdata`, with bits above bit 8 forced to zero. A write alone never raises `exc_req`. Register layout: bit 0 enable, bit 1 overflow, bit 2 underflow, bit 3 divide-by-zero, bit 4 inexact, bit 5 invalid, bit 6 signalling-NaN, bit 7 quiet-NaN, bit 8 infinity.
- R3: With enable set, any of the invalid sub-causes sets flag bit 5. The sub-causes sit at status bits 4 (signalling NaN), 5 (quiet NaN), 6 (inf minus inf), 7 (inf divided by inf), 8 (zero divided by zero), 9 (inf times zero), 10 (invalid conversion), 11 (invalid compare) and 12 (invalid square root).
- R4: Status bit 4 also sets flag bit 6, and status bit 5 also sets flag bit 7. No other status bit sets either flag.
- R5: Flag bit 8 (infinity) is set only by status bit 6 or 7.
- R6: The following status bits set flags: status bit 0 (overflow) sets flag bit 1, status bit 1 (underflow) sets flag bit 2, status bit 2 (divide-by-zero) sets flag bit 3, and status bit 3 (inexact) sets flag bit 4.
- R7: While enable (bit 0) is clear, a status strobe changes no flag and raises no request.
- R8: The update only ORs new flags in. A strobe never clears a flag, and all-zero status leaves the register unchanged.
- R9: In the cycle after an enabled strobe edge, `exc_req` is high exactly when any of the eight flags is set after the update, old flags included. It stays high for one cycle for each strobe.
- R10: When a write and a strobe occur in the same cycle, the write wins. The strobe's status is discarded and no request is raised.
- R11: Status bits are ignored while `st_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Status vector strobe from the arithmetic unit |
| st_bits | input | 13 | Per-operation status causes (positions in R3, R6) |
| csr_we | input | 1 | Software write enable for the register |
| csr_wdata | input | REG_W (16) | Software write data |
| csr_q | output | REG_W (16) | Current register value (enable plus flags) |
| exc_req | output | 1 | One-cycle floating-point exception request |

## Verification
The assertions assume a registered request and that `st_valid`, `st_bits`, `csr_we` and `csr_wdata` are steady around each rising edge. The bench meets this by changing every input on the falling edge only. The stickiness and stability properties only hold on cycles without a write, so they are conditioned on `csr_we` being low. The bench keeps each write in a separate cycle from the strobe it sets up, except in the one directed case that exercises the write-wins collision.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   // status vector positions
   localparam int ST_OVF  = 0;
   localparam int ST_UNF  = 1;
   localparam int ST_DZ   = 2;
   localparam int ST_IX   = 3;
   localparam int ST_SNAN = 4;
   localparam int ST_QNAN = 5;
   localparam int ST_ISI  = 6;
   localparam int ST_IDI  = 7;
   localparam int ST_ZDZ  = 8;
   localparam int ST_IMZ  = 9;
   localparam int ST_CVI  = 10;
   localparam int ST_CMP  = 11;
   localparam int ST_SQRT = 12;
   localparam int ST_W    = 13;
   localparam int INV_LO  = ST_SNAN;
   localparam int INV_HI  = ST_SQRT;

   // register bit positions
   localparam int FB_EN   = 0;
   localparam int FB_OVF  = 1;
   localparam int FB_UNF  = 2;
   localparam int FB_DZ   = 3;
   localparam int FB_IX   = 4;
   localparam int FB_IV   = 5;
   localparam int FB_SN   = 6;
   localparam int FB_QN   = 7;
   localparam int FB_INF  = 8;
   localparam int FLAG_N  = 8;
   localparam int CSR_USED = FLAG_N + 1;
endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
   import fpx_pkg::*;
(
   input  logic [ST_W-1:0]   st,
   output logic [FLAG_N-1:0] set_flags   // index k = register bit k+1
);
   localparam int NDIRECT = 4;

   // direct one-to-one causes: overflow, underflow, div-by-zero, inexact
   for (genvar k = 0; k < NDIRECT; k++) begin : g_direct
      assign set_flags[FB_OVF - 1 + k] = st[ST_OVF + k];
   end

   always_comb begin
      set_flags[FB_IV  - 1] = |st[INV_HI:INV_LO];
      set_flags[FB_SN  - 1] = st[ST_SNAN];
      set_flags[FB_QN  - 1] = st[ST_QNAN];
      set_flags[FB_INF - 1] = st[ST_ISI] | st[ST_IDI];
   end
endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg
   import fpx_pkg::*;
#(
   parameter int REG_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   input  logic              upd,
   input  logic [FLAG_N-1:0] set_flags,
   output logic [REG_W-1:0]  q
);
   localparam logic [REG_W-1:0] KEEP = REG_W'((64'd1 << CSR_USED) - 64'd1);

   logic [REG_W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (we) begin
         q_r <= wdata & KEEP;
      end else if (upd) begin
         q_r[FB_INF:FB_OVF] <= q_r[FB_INF:FB_OVF] | set_flags;
      end
   end

   assign q = q_r;
endmodule

// File: rtl/fpx_req_gen.sv
module fpx_req_gen
   import fpx_pkg::*;
#(
   parameter bit REQ_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [FLAG_N-1:0] flags_next,
   output logic              req
);
   logic want;
   assign want = fire & (|flags_next);

   if (REQ_REG) begin : g_reg
      logic req_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_r <= 1'b0;
         else        req_r <= want;
      end
      assign req = req_r;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign req = want;
   end
endmodule

// File: rtl/fpx_collector.sv
module fpx_collector
   import fpx_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter bit REQ_REG = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             st_valid,
   input  logic [12:0]      st_bits,
   input  logic             csr_we,
   input  logic [REG_W-1:0] csr_wdata,
   output logic [REG_W-1:0] csr_q,
   output logic             exc_req
);
   if (REG_W < CSR_USED) begin : g_bad_width
      $error("fpx_collector: REG_W must hold enable plus eight flags");
   end
   if (ST_W != 13) begin : g_bad_status
      $error("fpx_collector: status width mismatch");
   end

   logic [FLAG_N-1:0] set_flags;
   logic [FLAG_N-1:0] flags_next;
   logic              fire;

   fpx_cause_map u_map (
      .st        (st_bits),
      .set_flags (set_flags)
   );

   // update only on an enabled strobe that does not collide with a write
   assign fire       = st_valid & csr_q[FB_EN] & ~csr_we;
   assign flags_next = csr_q[FB_INF:FB_OVF] | set_flags;

   fpx_flag_reg #(.REG_W(REG_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (csr_we),
      .wdata     (csr_wdata),
      .upd       (fire),
      .set_flags (set_flags),
      .q         (csr_q)
   );

   fpx_req_gen #(.REQ_REG(REQ_REG)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .flags_next (flags_next),
      .req        (exc_req)
   );
endmodule

// File: rtl/fpx_collector_chk.sv
module fpx_collector_chk #(
   parameter int REG_W   = 16,
   parameter bit REQ_REG = 1'b1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             st_valid,
   input logic             csr_we,
   input logic [REG_W-1:0] csr_wdata,
   input logic [REG_W-1:0] csr_q,
   input logic             exc_req
);
   localparam logic [REG_W-1:0] KEEP = REG_W'((64'd1 << 9) - 64'd1);

   assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      csr_we |=> csr_q == ($past(csr_wdata) & KEEP));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_we |=> ((csr_q[8:1] & $past(csr_q[8:1])) == $past(csr_q[8:1])));

   assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && !csr_q[0]) |=> $stable(csr_q));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_valid && !csr_we) |=> $stable(csr_q));

   if (REQ_REG) begin : g_req_checks
      assert_disabled_noreq_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !csr_q[0] |=> !exc_req);

      assert_idle_noreq_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !st_valid |=> !exc_req);

      assert_write_noreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
         csr_we |=> !exc_req);

      assert_req_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (st_valid && !csr_we && csr_q[0]) |=> (exc_req == (|csr_q[8:1])));
   end
endmodule

bind fpx_collector fpx_collector_chk #(.REG_W(REG_W), .REQ_REG(REQ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_valid  (st_valid),
   .csr_we    (csr_we),
   .csr_wdata (csr_wdata),
   .csr_q     (csr_q),
   .exc_req   (exc_req)
);

// File: tb/fpx_collector_test.sv
module fpx_collector_test;
   localparam int W = 16;

   // register fields
   localparam logic [15:0] EN  = 16'h001, OVF = 16'h002, UNF = 16'h004,
                           DZ  = 16'h008, IX  = 16'h010, IV  = 16'h020,
                           SN  = 16'h040, QN  = 16'h080, INF = 16'h100;
   // status causes
   localparam logic [15:0] S_OVF = 16'h0001, S_UNF = 16'h0002, S_DZ = 16'h0004,
                           S_IX = 16'h0008, S_SNAN = 16'h0010, S_QNAN = 16'h0020,
                           S_ISI = 16'h0040, S_IDI = 16'h0080, S_ZDZ = 16'h0100,
                           S_IMZ = 16'h0200, S_CVI = 16'h0400, S_CMP = 16'h0800,
                           S_SQRT = 16'h1000;

   // {req id[3:0], init[15:0], status[15:0], expected csr[15:0], expected req}
   localparam int NV = 19;
   localparam logic [52:0] VEC [NV] = '{
      {4'd4, EN,      S_SNAN, EN|IV|SN,  1'b1},  // R3 R4
      {4'd4, EN,      S_QNAN, EN|IV|QN,  1'b1},  // R3 R4
      {4'd5, EN,      S_ISI,  EN|IV|INF, 1'b1},  // R5
      {4'd5, EN,      S_IDI,  EN|IV|INF, 1'b1},  // R5
      {4'd3, EN,      S_ZDZ,  EN|IV,     1'b1},  // R3
      {4'd3, EN,      S_IMZ,  EN|IV,     1'b1},  // R3
      {4'd3, EN,      S_CVI,  EN|IV,     1'b1},  // R3
      {4'd3, EN,      S_CMP,  EN|IV,     1'b1},  // R3
      {4'd3, EN,      S_SQRT, EN|IV,     1'b1},  // R3
      {4'd6, EN,      S_OVF,  EN|OVF,    1'b1},  // R6
      {4'd6, EN,      S_UNF,  EN|UNF,    1'b1},  // R6
      {4'd6, EN,      S_DZ,   EN|DZ,     1'b1},  // R6
      {4'd6, EN,      S_IX,   EN|IX,     1'b1},  // R6
      {4'd9, EN,      16'h0,  EN,        1'b0},  // R9 nothing set
      {4'd9, EN|DZ,   16'h0,  EN|DZ,     1'b1},  // R9 leftover flag
      {4'd8, EN|OVF,  S_IX,   EN|OVF|IX, 1'b1},  // R8 sticky
      {4'd7, 16'h0,   S_SNAN, 16'h0,     1'b0},  // R7 disabled
      {4'd7, DZ,      S_OVF,  DZ,        1'b0},  // R7 disabled, old flag
      {4'd3, EN,      16'h1FFF, 16'h1FF, 1'b1}   // R3 all causes
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [12:0]   st_bits = '0;
   logic          csr_we = 1'b0;
   logic [W-1:0]  csr_wdata = '0;
   logic [W-1:0]  csr_q;
   logic          exc_req;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fpx_collector #(.REG_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_bits(st_bits),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_q(csr_q), .exc_req(exc_req)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_csr(input logic [15:0] v);
      @(negedge clk);
      csr_we = 1'b1; csr_wdata = v; st_valid = 1'b0;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 csr after reset", csr_q, 16'h0);
      check("R1 req after reset", {15'b0, exc_req}, 16'h0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  rid;
         logic [15:0] init, st, exp;
         logic        ereq;
         {rid, init, st, exp, ereq} = VEC[i];
         write_csr(init);
         st_valid = 1'b1; st_bits = st[12:0];
         @(negedge clk);
         st_valid = 1'b0; st_bits = '0;
         check($sformatf("R%0d vec %0d csr", rid, i), csr_q, exp);
         check($sformatf("R%0d vec %0d req", rid, i), {15'b0, exc_req}, {15'b0, ereq});
         @(negedge clk);
         check($sformatf("R9 vec %0d pulse ends", i), {15'b0, exc_req}, 16'h0);
      end

      // R2: upper bits masked, write raises no request
      write_csr(16'hFFFF);
      check("R2 masked write", csr_q, 16'h01FF);
      check("R2 no req on write", {15'b0, exc_req}, 16'h0);
      write_csr(16'h0000);
      check("R2 write clears", csr_q, 16'h0);

      // R10: write and strobe in the same cycle
      write_csr(EN);
      @(negedge clk);
      csr_we = 1'b1; csr_wdata = EN | UNF;
      st_valid = 1'b1; st_bits = S_OVF[12:0];
      @(negedge clk);
      csr_we = 1'b0; st_valid = 1'b0; st_bits = '0;
      check("R10 write wins", csr_q, EN | UNF);
      check("R10 no req", {15'b0, exc_req}, 16'h0);

      // R11: status bits without strobe
      write_csr(EN);
      @(negedge clk);
      st_bits = 13'h1FFF;
      @(negedge clk);
      st_bits = '0;
      check("R11 no update", csr_q, EN);
      check("R11 no req", {15'b0, exc_req}, 16'h0);

      // R8: repeated strobes accumulate
      st_valid = 1'b1; st_bits = S_OVF[12:0];
      @(negedge clk);
      st_bits = S_UNF[12:0];
      @(negedge clk);
      st_valid = 1'b0; st_bits = '0;
      check("R8 accumulate", csr_q, EN | OVF | UNF);
      check("R9 back-to-back req", {15'b0, exc_req}, 16'h1);

      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears csr", csr_q, 16'h0);
      check("R1 reset clears req", {15'b0, exc_req}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule